// File: doc/BRIEF.md
# Double-Buffered Tile Binning Engine

This block sorts screen-space primitives into per-tile lists for a tile-based rasterizer. Each incoming primitive arrives as an index and an axis-aligned pixel bounding box. The engine works out every screen tile the box overlaps and appends the index to each of those tiles' lists. The screen has 8 by 8 tiles of 16 by 16 pixels. A tile list holds at most 16 entries, and each list has a sticky flag that records any primitive that did not fit.

Two complete sets of tile lists alternate between roles. One set collects the frame now arriving, while the other set is streamed out, tile by tile, to the rasterizer. An end-of-frame beat on the input closes a frame and carries a one-bit depth-readback request. When the read-out side has drained the older frame, the two sets swap. The closed frame is then streamed out with its readback request attached to every beat. Because of this, input never waits on raster progress, except at a frame boundary when the previous frame has not yet been drained.

Walking the tiles of a primitive takes one cycle per overlapped tile, and the input stalls during the walk. The read-out port uses a valid/ready handshake. It emits one beat per stored index, or a single empty beat for a tile with no entries, and marks the final beat of each tile.

Top module: `tile_binner`

## Requirements
- R1: Input acceptance does not depend on the read-out port. While the read-out side is stalled with `out_ready` low, `in_ready` is high whenever no tile walk is in progress and no closed frame is waiting to swap.
- R2: The two bin sets alternate. Frame N is streamed out while frame N+1 is collected, and frames leave in the order they were closed.
- R3: A primitive with an on-screen box is added to every tile (tx, ty) with x0>>4 ≤ tx ≤ min(x1>>4, 7) and y0>>4 ≤ ty ≤ min(y1>>4, 7). Boxes must satisfy x0 ≤ x1 and y0 ≤ y1.
- R4: Each tile list keeps its first 16 indices in arrival order, and further indices for that tile in that frame are dropped.
- R5: `out_ovf` is 1 on every beat of a tile for which an index was dropped in that frame, and 0 otherwise. The flag does not carry into later frames.
- R6: A swap happens only after an end-of-frame beat has been accepted and the previous frame's read-out has finished all 64 tiles. Until the swap, `in_ready` stays low.
- R7: Read-out visits tiles in raster order, with `out_tile` = ty*8+tx. `out_last` is 1 on the final beat of each tile. While `out_valid` is high and `out_ready` is low, the output beat holds still.
- R8: A tile with no entries produces exactly one beat, with `out_empty`=1 and `out_last`=1.
- R9: A primitive with x0>>4 ≥ 8 or y0>>4 ≥ 8 is consumed without stalling and placed in no tile.
- R10: The `in_zread` value on a frame's end-of-frame beat appears on `out_zread` for every beat of that frame's read-out.
- R11: After reset, `in_ready` is 1 and `out_valid` is 0, and both bin sets are empty.
- R12: After accepting a primitive that overlaps n tiles, `in_ready` is low for exactly n cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_eof | input | 1 | Beat is an end-of-frame marker (box and index ignored) |
| in_zread | input | 1 | Depth readback request, sampled on the end-of-frame beat |
| in_idx | input | 8 | Primitive index |
| in_xmin | input | 10 | Box left pixel column |
| in_ymin | input | 10 | Box top pixel row |
| in_xmax | input | 10 | Box right pixel column |
| in_ymax | input | 10 | Box bottom pixel row |
| out_valid | output | 1 | Read-out beat valid |
| out_ready | input | 1 | Rasterizer accepts read-out beat |
| out_tile | output | 6 | Tile number, ty*8+tx |
| out_idx | output | 8 | Primitive index (meaningless on empty beat) |
| out_last | output | 1 | Final beat of this tile |
| out_empty | output | 1 | Tile has no entries |
| out_ovf | output | 1 | Tile dropped at least one index this frame |
| out_zread | output | 1 | Depth readback request of the frame being read |

## Verification
The bench builds the block with its package defaults: an 8x8 grid of 16-pixel tiles, 16-entry lists and 10-bit coordinates. The coordinate range reaches well past the 128-pixel screen edge, so boxes that start off screen and boxes that are clamped at the right and bottom edges both occur. With only 16 entries per list, twenty primitives aimed at one tile reach the overflow path inside a single frame. Eight frames are run, so each bin set is filled and drained four times. This exposes any state left over after a swap, and a long read-out stall makes the swap gate observable.

// File: rtl/tbin_pkg.sv
package tbin_pkg;
    localparam int TX     = 8;
    localparam int TY     = 8;
    localparam int TSHIFT = 4;
    localparam int DEPTH  = 16;
    localparam int IDXW   = 8;
    localparam int CW     = 10;

    localparam int NT     = TX * TY;
    localparam int TW     = $clog2(NT);
    localparam int TXW    = $clog2(TX);
    localparam int TYW    = $clog2(TY);
    localparam int CNTW   = $clog2(DEPTH + 1);
    localparam int PW     = $clog2(DEPTH);
    localparam int SW     = $clog2(2 * NT);
    localparam int AW     = $clog2(2 * NT * DEPTH);

    typedef struct packed {
        logic [CW-1:0] x0;
        logic [CW-1:0] y0;
        logic [CW-1:0] x1;
        logic [CW-1:0] y1;
    } box_t;

    typedef struct packed {
        logic            en;
        logic [TW-1:0]   tile;
        logic [IDXW-1:0] idx;
    } binwr_t;

    function automatic logic [TW-1:0] tile_of(input logic [TXW-1:0] x, input logic [TYW-1:0] y);
        return TW'(int'(y) * TX + int'(x));
    endfunction

    function automatic logic [SW-1:0] slot_of(input logic bank, input logic [TW-1:0] tile);
        return SW'(int'(bank) * NT + int'(tile));
    endfunction
endpackage

// File: rtl/tbin_walker.sv
module tbin_walker
    import tbin_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  box_t            box,
    input  logic [IDXW-1:0] idx,
    output logic            busy,
    output binwr_t          wr
);
    logic [CW-1:0]   lo_x, lo_y, hi_x, hi_y;
    logic            off;
    logic [TXW-1:0]  cx, x_lo, x_hi;
    logic [TYW-1:0]  cy, y_hi;
    logic [IDXW-1:0] idx_q;

    always_comb begin
        lo_x = box.x0 >> TSHIFT;
        lo_y = box.y0 >> TSHIFT;
        hi_x = box.x1 >> TSHIFT;
        hi_y = box.y1 >> TSHIFT;
        if (hi_x > CW'(TX - 1)) hi_x = CW'(TX - 1);
        if (hi_y > CW'(TY - 1)) hi_y = CW'(TY - 1);
        off = (lo_x >= CW'(TX)) || (lo_y >= CW'(TY));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cx    <= '0;
            cy    <= '0;
            x_lo  <= '0;
            x_hi  <= '0;
            y_hi  <= '0;
            idx_q <= '0;
        end else if (start && !off) begin
            busy  <= 1'b1;
            cx    <= lo_x[TXW-1:0];
            cy    <= lo_y[TYW-1:0];
            x_lo  <= lo_x[TXW-1:0];
            x_hi  <= hi_x[TXW-1:0];
            y_hi  <= hi_y[TYW-1:0];
            idx_q <= idx;
        end else if (busy) begin
            if (cx == x_hi) begin
                cx <= x_lo;
                if (cy == y_hi) busy <= 1'b0;
                else            cy   <= cy + 1'b1;
            end else begin
                cx <= cx + 1'b1;
            end
        end
    end

    always_comb begin
        wr.en   = busy;
        wr.tile = tile_of(cx, cy);
        wr.idx  = idx_q;
    end

    // R1/R12: the top must never hand over a new primitive mid-walk
    p_walk_idle_start_r12: assert property (@(posedge clk) disable iff (rst)
        start |-> !busy);
    // R3: the walk stays inside the clamped tile rectangle
    p_walk_span_r3: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cx >= x_lo) && (cx <= x_hi) && (cy <= y_hi));
endmodule

// File: rtl/tbin_store.sv
module tbin_store
    import tbin_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wbank,
    input  binwr_t          wr,
    input  logic            rbank,
    input  logic [TW-1:0]   rtile,
    input  logic [PW-1:0]   rpos,
    input  logic            clr,
    output logic [CNTW-1:0] rcnt,
    output logic            rovf,
    output logic [IDXW-1:0] ridx
);
    logic [IDXW-1:0] mem [2*NT*DEPTH];
    logic [CNTW-1:0] cnt [2*NT];
    logic [2*NT-1:0] ovf;

    logic [SW-1:0]   wslot, rslot;
    logic [CNTW-1:0] wcnt;
    logic            wfits;

    always_comb begin
        wslot = slot_of(wbank, wr.tile);
        rslot = slot_of(rbank, rtile);
        wcnt  = cnt[wslot];
        wfits = wcnt < CNTW'(DEPTH);
    end

    always_ff @(posedge clk) begin
        if (wr.en && wfits)
            mem[AW'(int'(wslot) * DEPTH + int'(wcnt))] <= wr.idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 2 * NT; i++) cnt[i] <= '0;
            ovf <= '0;
        end else begin
            if (wr.en) begin
                if (wfits) cnt[wslot] <= wcnt + CNTW'(1);
                else       ovf[wslot] <= 1'b1;
            end
            if (clr) begin
                cnt[rslot] <= '0;
                ovf[rslot] <= 1'b0;
            end
        end
    end

    always_comb begin
        rcnt = cnt[rslot];
        rovf = ovf[rslot];
        ridx = mem[AW'(int'(rslot) * DEPTH + int'(rpos))];
    end

    // R2: collection and read-out always touch different bin sets
    p_bank_split_r2: assert property (@(posedge clk) disable iff (rst)
        (wr.en && clr) |-> (wbank != rbank));
    // R5: a write into a full list raises that list's overflow flag
    p_ovf_set_r5: assert property (@(posedge clk) disable iff (rst)
        (wr.en && !wfits) |=> ovf[$past(wslot)]);
endmodule

// File: rtl/tbin_reader.sv
module tbin_reader
    import tbin_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            zin,
    input  logic [CNTW-1:0] rcnt,
    input  logic            rovf,
    input  logic [IDXW-1:0] ridx,
    input  logic            out_ready,
    output logic            out_valid,
    output logic [TW-1:0]   out_tile,
    output logic [IDXW-1:0] out_idx,
    output logic            out_last,
    output logic            out_empty,
    output logic            out_ovf,
    output logic            out_zread,
    output logic [PW-1:0]   rpos,
    output logic            clr
);
    logic          run, zq;
    logic [TW-1:0] tile;
    logic [PW-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            run  <= 1'b0;
            zq   <= 1'b0;
            tile <= '0;
            pos  <= '0;
        end else if (start) begin
            run  <= 1'b1;
            zq   <= zin;
            tile <= '0;
            pos  <= '0;
        end else if (run && out_ready) begin
            if (out_last) begin
                pos <= '0;
                if (tile == TW'(NT - 1)) run  <= 1'b0;
                else                     tile <= tile + 1'b1;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    always_comb begin
        out_valid = run;
        out_tile  = tile;
        out_idx   = ridx;
        out_empty = (rcnt == '0);
        out_last  = out_empty || ({1'b0, pos} == rcnt - CNTW'(1));
        out_ovf   = rovf;
        out_zread = zq;
        rpos      = pos;
        clr       = run && out_ready && out_last;
    end

    // R6: a new frame may only start once the previous one has drained
    p_start_idle_r6: assert property (@(posedge clk) disable iff (rst)
        start |-> !run);
    // R7: a stalled beat holds still
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tile) && $stable(out_idx) && $stable(out_last)));
    // R7: tiles advance one at a time in raster order
    p_order_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last && (out_tile != TW'(NT - 1))) |=> (out_tile == $past(out_tile) + 1'b1));
    // R10: the readback flag is constant through a frame
    p_zread_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && $past(out_valid)) |-> $stable(out_zread));
endmodule

// File: rtl/tile_binner.sv
module tile_binner
    import tbin_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    output logic            in_ready,
    input  logic            in_eof,
    input  logic            in_zread,
    input  logic [IDXW-1:0] in_idx,
    input  logic [CW-1:0]   in_xmin,
    input  logic [CW-1:0]   in_ymin,
    input  logic [CW-1:0]   in_xmax,
    input  logic [CW-1:0]   in_ymax,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [TW-1:0]   out_tile,
    output logic [IDXW-1:0] out_idx,
    output logic            out_last,
    output logic            out_empty,
    output logic            out_ovf,
    output logic            out_zread
);
    logic            bin_bank, rd_bank, eof_seen, pend_z;
    logic            walk_busy, accept, prim_acc, eof_acc, swap;
    box_t            box;
    binwr_t          wr;
    logic [CNTW-1:0] rcnt;
    logic            rovf, clr;
    logic [IDXW-1:0] ridx;
    logic [PW-1:0]   rpos;

    always_comb begin
        in_ready = !walk_busy && !eof_seen;
        accept   = in_valid && in_ready;
        prim_acc = accept && !in_eof;
        eof_acc  = accept && in_eof;
        swap     = eof_seen && !walk_busy && !out_valid;
        box      = '{x0: in_xmin, y0: in_ymin, x1: in_xmax, y1: in_ymax};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_bank <= 1'b0;
            rd_bank  <= 1'b1;
            eof_seen <= 1'b0;
            pend_z   <= 1'b0;
        end else if (swap) begin
            bin_bank <= ~bin_bank;
            rd_bank  <= bin_bank;
            eof_seen <= 1'b0;
        end else if (eof_acc) begin
            eof_seen <= 1'b1;
            pend_z   <= in_zread;
        end
    end

    tbin_walker u_walk (
        .clk  (clk),
        .rst  (rst),
        .start(prim_acc),
        .box  (box),
        .idx  (in_idx),
        .busy (walk_busy),
        .wr   (wr)
    );

    tbin_store u_store (
        .clk  (clk),
        .rst  (rst),
        .wbank(bin_bank),
        .wr   (wr),
        .rbank(rd_bank),
        .rtile(out_tile),
        .rpos (rpos),
        .clr  (clr),
        .rcnt (rcnt),
        .rovf (rovf),
        .ridx (ridx)
    );

    tbin_reader u_read (
        .clk      (clk),
        .rst      (rst),
        .start    (swap),
        .zin      (pend_z),
        .rcnt     (rcnt),
        .rovf     (rovf),
        .ridx     (ridx),
        .out_ready(out_ready),
        .out_valid(out_valid),
        .out_tile (out_tile),
        .out_idx  (out_idx),
        .out_last (out_last),
        .out_empty(out_empty),
        .out_ovf  (out_ovf),
        .out_zread(out_zread),
        .rpos     (rpos),
        .clr      (clr)
    );

    // R6: the bin sets only trade roles after a closed frame and a drained read-out
    p_swap_gate_r6: assert property (@(posedge clk) disable iff (rst)
        (bin_bank != $past(bin_bank)) |-> ($past(eof_seen) && !$past(out_valid)));
    // R2: the set being read is never the set being filled
    p_banks_differ_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (rd_bank != bin_bank));
endmodule

// File: tb/test_tile_binner.sv
module test_tile_binner;
    import tbin_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NFRAMES    = 8;

    logic            clk = 1'b0;
    logic            rst;
    logic            in_valid, in_ready, in_eof, in_zread;
    logic [IDXW-1:0] in_idx;
    logic [CW-1:0]   in_xmin, in_ymin, in_xmax, in_ymax;
    logic            out_valid, out_ready, out_last, out_empty, out_ovf, out_zread;
    logic [TW-1:0]   out_tile;
    logic [IDXW-1:0] out_idx;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tile_binner i_tile_binner (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_eof(in_eof), .in_zread(in_zread),
        .in_idx(in_idx), .in_xmin(in_xmin), .in_ymin(in_ymin), .in_xmax(in_xmax), .in_ymax(in_ymax),
        .out_valid(out_valid), .out_ready(out_ready), .out_tile(out_tile), .out_idx(out_idx),
        .out_last(out_last), .out_empty(out_empty), .out_ovf(out_ovf), .out_zread(out_zread)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit stall = 0;
    int frames_read = 0;
    int bf = 0;

    int exp_cnt  [4][NT];
    int exp_list [4][NT][DEPTH];
    bit exp_ovf  [4][NT];
    bit exp_z    [4];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic void clear_slot(input int f);
        for (int t = 0; t < NT; t++) begin
            exp_cnt[f % 4][t] = 0;
            exp_ovf[f % 4][t] = 0;
        end
        exp_z[f % 4] = 0;
    endfunction

    function automatic void model_add(input int f, input int idx, input int x0, input int y0,
                                      input int x1, input int y1);
        int tx0 = x0 >> TSHIFT;
        int ty0 = y0 >> TSHIFT;
        int tx1 = x1 >> TSHIFT;
        int ty1 = y1 >> TSHIFT;
        int s = f % 4;
        if (tx0 >= TX || ty0 >= TY) return;
        if (tx1 > TX - 1) tx1 = TX - 1;
        if (ty1 > TY - 1) ty1 = TY - 1;
        for (int ty = ty0; ty <= ty1; ty++) begin
            for (int tx = tx0; tx <= tx1; tx++) begin
                int t = ty * TX + tx;
                if (exp_cnt[s][t] < DEPTH) begin
                    exp_list[s][t][exp_cnt[s][t]] = idx;
                    exp_cnt[s][t]++;
                end else begin
                    exp_ovf[s][t] = 1;
                end
            end
        end
    endfunction

    // called at a negedge, returns at the negedge after acceptance
    task automatic push(input int idx, input int x0, input int y0, input int x1, input int y1);
        model_add(bf, idx, x0, y0, x1, y1);
        in_eof   = 1'b0;
        in_idx   = IDXW'(idx);
        in_xmin  = CW'(x0);
        in_ymin  = CW'(y0);
        in_xmax  = CW'(x1);
        in_ymax  = CW'(y1);
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic push_eof(input bit z);
        exp_z[bf % 4] = z;
        in_eof   = 1'b1;
        in_zread = z;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_eof   = 1'b0;
        bf++;
        clear_slot(bf);
    endtask

    task automatic random_frame(input int n);
        for (int i = 0; i < n; i++) begin
            int x0 = $urandom % 160;
            int y0 = $urandom % 160;
            push($urandom % 256, x0, y0, x0 + ($urandom % 40), y0 + ($urandom % 40));
        end
    endtask

    // read-out consumer and checker
    initial begin : consumer
        int et = 0;
        int ep = 0;
        int s;
        int n;
        out_ready = 1'b0;
        forever begin
            @(negedge clk);
            if (rst) continue;
            out_ready = stall ? 1'b0 : ($urandom % 4 != 0);
            if (out_valid && out_ready) begin
                s = frames_read % 4;
                n = exp_cnt[s][et];
                chk(out_tile == TW'(et), "R7 raster tile order", int'(out_tile), et);
                chk(out_zread == exp_z[s], "R10 frame readback flag", int'(out_zread), int'(exp_z[s]));
                chk(out_ovf == exp_ovf[s][et], "R5 overflow flag", int'(out_ovf), int'(exp_ovf[s][et]));
                if (n == 0) begin
                    chk(out_empty && out_last, "R8 empty tile beat", int'({out_empty, out_last}), 3);
                end else begin
                    chk(!out_empty && out_idx == IDXW'(exp_list[s][et][ep]),
                        "R3/R4 bin contents in arrival order", int'(out_idx), exp_list[s][et][ep]);
                    chk(out_last == (ep == n - 1), "R7 end-of-tile marker", int'(out_last), int'(ep == n - 1));
                end
                if (n == 0 || ep == n - 1) begin
                    ep = 0;
                    if (et == NT - 1) begin
                        et = 0;
                        frames_read++;   // R2: frames complete in closing order
                    end else begin
                        et++;
                    end
                end else begin
                    ep++;
                end
            end
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog expired, frames read actual=%0d expected=%0d", frames_read, NFRAMES);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stimulus
        int lowc;
        void'($urandom(32'd24681));
        rst = 1'b1; in_valid = 1'b0; in_eof = 1'b0; in_zread = 1'b0;
        in_idx = '0; in_xmin = '0; in_ymin = '0; in_xmax = '0; in_ymax = '0;
        clear_slot(0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1, "R11 reset in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R11 reset out_valid", int'(out_valid), 0);

        // frame 0: directed corner cases
        push(1, 0, 0, 31, 47);              // 2 x 3 tiles
        lowc = 0;
        while (!in_ready) begin lowc++; @(negedge clk); end
        chk(lowc == 6, "R12 walk cycles for 6 tiles", lowc, 6);
        push(2, 130, 5, 200, 50);           // off screen in x
        chk(in_ready == 1'b1, "R9 off-screen x consumed without stall", int'(in_ready), 1);
        push(3, 5, 128, 20, 140);           // off screen in y
        chk(in_ready == 1'b1, "R9 off-screen y consumed without stall", int'(in_ready), 1);
        push(4, 100, 100, 300, 300);        // clamped at right and bottom edge
        for (int i = 0; i < 20; i++) push(10 + i, 16, 16, 20, 20);   // overflow tile 9
        push(40, 0, 0, 127, 127);           // whole screen
        push_eof(1'b1);
        stall = 1'b1;

        // frame 1: bin while read-out is held off
        repeat (3) @(negedge clk);
        chk(in_ready && out_valid, "R1 input open while read-out stalled", int'({in_ready, out_valid}), 3);
        random_frame(12);
        push_eof(1'b0);
        repeat (30) @(negedge clk);
        chk(in_ready == 1'b0, "R6 no swap before read-out done", int'(in_ready), 0);
        chk(out_valid && out_tile == '0, "R2 older frame still held at tile 0", int'(out_tile), 0);
        stall = 1'b0;

        for (int f = 2; f < NFRAMES; f++) begin
            random_frame(6 + ($urandom % 20));
            push_eof(bit'($urandom % 2));
        end

        while (frames_read < NFRAMES) @(negedge clk);
        chk(frames_read == NFRAMES, "R2 all frames read out", frames_read, NFRAMES);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule